// File: doc/BRIEF.md
# Interrupt-Capable 32-Pin I/O Port

This block is one general-purpose I/O port of a chip. Its register file sits on a plain strobe bus. Software uses it to drive pin values and their output enables, to read back the pin levels, and to watch pins for events. Each pin can raise a sticky status flag on a rising edge, a falling edge, a high level or a low level. All flags that are enabled are combined into one interrupt line for the whole port.

Each register takes one bit per pin and owns a 16-byte address slot. Inside a slot, the word offset selects the kind of write. Offset 0x0 replaces the contents. Offset 0x4 sets the bits written as one. Offset 0x8 clears the bits written as one. Software can therefore change single pins without a read-modify-write. Pin inputs are synchronised before they reach the input register and the event detector.

Top module: `gpio_irq_port`

## Requirements
- R1: After a synchronous reset every register reads zero, and pin_out, pin_oe and irq are all low.
- R2: Byte offset 0x0 inside a slot loads wdata. Offset 0x4 ORs wdata into the register. Offset 0x8 clears the bits that are one in wdata. A write at offset 0xC changes nothing.
- R3: The slot index is addr[6:4]: 0 output data, 1 input data, 2 output enable, 3 interrupt select, 4 interrupt enable, 5 level mode, 6 polarity, 7 status. pin_out shows the output data register and pin_oe shows the output enable register.
- R4: rdata is registered and is valid in the cycle after rd_en. A read at any offset in a slot returns that slot's register value.
- R5: The input data slot reads the pins after a two-flop synchroniser, and writes to that slot are ignored.
- R6: A pin's mode is {polarity, level}: 00 falling edge, 01 low level, 10 rising edge, 11 high level.
- R7: In an edge mode the status bit is set by the selected transition only, and it stays set after the pin returns to its earlier level.
- R8: In a level mode the status bit is set while the active level is present. If it is cleared while that level persists, it is set again at once.
- R9: A pin whose interrupt-select bit is 0 never sets its status bit.
- R10: Status bits are cleared by writing ones at the clear offset of the status slot. In the same cycle, a detected event takes priority over the clear.
- R11: irq is a registered output. It is high when some status bit and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Byte address: slot in [6:4], access kind in [3:2] |
| wdata | input | PINS | Write data |
| rdata | output | PINS | Registered read data |
| pin_in | input | PINS | Asynchronous pin levels |
| pin_out | output | PINS | Output data to the pads |
| pin_oe | output | PINS | Output enables to the pads |
| irq | output | 1 | Combined port interrupt |

## Verification
The bench builds the port with its default parameters: 32 pins and a 7-bit address. With these values all eight slots and all four access offsets can be reached, including the ignored offset 0xC. Random traffic across the writable slots and random pin patterns cover all 32 bit positions. Directed runs on a single pin take each of the four modes through arming, triggering, staying sticky and clearing, and they also show that the select and enable masks gate the status and the interrupt.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [2:0] {
    SLOT_DOUT = 3'd0,
    SLOT_DIN  = 3'd1,
    SLOT_OE   = 3'd2,
    SLOT_SEL  = 3'd3,
    SLOT_EN   = 3'd4,
    SLOT_LVL  = 3'd5,
    SLOT_POL  = 3'd6,
    SLOT_STAT = 3'd7
  } slot_e;

  typedef enum logic [1:0] {
    ACC_LOAD = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2,
    ACC_NONE = 2'd3
  } access_e;

  localparam int SLOT_LSB = 4;
  localparam int SLOT_W   = 3;
  localparam int ACC_LSB  = 2;
  localparam int ACC_W    = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] sel,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] pol,
  output logic [W-1:0] evt
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= pin_s;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, hit;
    assign rise = pin_s[i] & ~prev_q[i];
    assign fall = ~pin_s[i] & prev_q[i];
    always_comb begin
      unique case ({pol[i], lvl[i]})
        2'b00:   hit = fall;
        2'b01:   hit = ~pin_s[i];
        2'b10:   hit = rise;
        default: hit = pin_s[i];
      endcase
    end
    assign evt[i] = sel[i] & hit;
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 32,
  parameter int AW   = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic            irq
);
  localparam int SLOT_MSB = SLOT_LSB + SLOT_W - 1;
  localparam int ACC_MSB  = ACC_LSB + ACC_W - 1;

  slot_e   slot;
  access_e acc;
  assign slot = slot_e'(addr[SLOT_MSB:SLOT_LSB]);
  assign acc  = access_e'(addr[ACC_MSB:ACC_LSB]);

  logic unused_addr_bits;
  assign unused_addr_bits = ^addr;

  logic [PINS-1:0] dout_q, oe_q, sel_q, en_q, lvl_q, pol_q, stat_q;
  logic [PINS-1:0] pin_s, evt;
  logic            irq_q;

  gpio_sync #(.W(PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  gpio_irq_detect #(.W(PINS)) u_det (
    .clk(clk), .rst(rst), .pin_s(pin_s), .sel(sel_q),
    .lvl(lvl_q), .pol(pol_q), .evt(evt)
  );

  function automatic logic [PINS-1:0] upd(slot_e s, logic [PINS-1:0] cur);
    logic [PINS-1:0] r;
    r = cur;
    if (wr_en && slot == s) begin
      unique case (acc)
        ACC_LOAD: r = wdata;
        ACC_SET:  r = cur | wdata;
        ACC_CLR:  r = cur & ~wdata;
        default:  r = cur;
      endcase
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      oe_q   <= '0;
      sel_q  <= '0;
      en_q   <= '0;
      lvl_q  <= '0;
      pol_q  <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      dout_q <= upd(SLOT_DOUT, dout_q);
      oe_q   <= upd(SLOT_OE,   oe_q);
      sel_q  <= upd(SLOT_SEL,  sel_q);
      en_q   <= upd(SLOT_EN,   en_q);
      lvl_q  <= upd(SLOT_LVL,  lvl_q);
      pol_q  <= upd(SLOT_POL,  pol_q);
      stat_q <= upd(SLOT_STAT, stat_q) | evt;
      irq_q  <= |(stat_q & en_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      unique case (slot)
        SLOT_DOUT: rdata <= dout_q;
        SLOT_DIN:  rdata <= pin_s;
        SLOT_OE:   rdata <= oe_q;
        SLOT_SEL:  rdata <= sel_q;
        SLOT_EN:   rdata <= en_q;
        SLOT_LVL:  rdata <= lvl_q;
        SLOT_POL:  rdata <= pol_q;
        default:   rdata <= stat_q;
      endcase
    end
  end

  assign pin_out = dout_q;
  assign pin_oe  = oe_q;
  assign irq     = irq_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int PINS = 32,
  parameter int AW   = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [PINS-1:0] stat_q,
  input logic [PINS-1:0] en_q,
  input logic [PINS-1:0] sel_q,
  input logic [PINS-1:0] pin_out,
  input logic [PINS-1:0] pin_oe,
  input logic            irq
);
  logic stat_wr, dout_wr;
  assign stat_wr = wr_en && (addr[6:4] == 3'd7);
  assign dout_wr = wr_en && (addr[6:4] == 3'd0);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (irq == 1'b0 && pin_oe == '0 && pin_out == '0));

  // R11
  irq_combine_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == $past(|(stat_q & en_q))));

  // R10
  stat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !stat_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R9
  sel_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !stat_wr |=> ((stat_q & ~$past(stat_q) & ~$past(sel_q)) == '0));

  // R3
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dout_wr |=> $stable(pin_out));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.PINS(PINS), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .stat_q(stat_q),
  .en_q(en_q), .sel_q(sel_q), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
  localparam int PINS = 32;
  localparam int AW   = 7;
  localparam int P    = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [PINS-1:0] wdata = '0, rdata, pin_in = '0, pin_out, pin_oe;
  logic            irq;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_irq_port #(.PINS(PINS), .AW(AW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq)
  );

  function automatic logic [PINS-1:0] model(logic [PINS-1:0] cur, int a, logic [PINS-1:0] d);
    case (a)
      0: return d;
      1: return cur | d;
      2: return cur & ~d;
      default: return cur;
    endcase
  endfunction

  task automatic check(string req, logic [PINS-1:0] act, logic [PINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int slot, int a, logic [PINS-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(slot * 16 + a * 4); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int slot, int a, output logic [PINS-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(slot * 16 + a * 4);
    @(negedge clk);
    rd_en = 1'b0; d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  // Drive pin P through one mode and check the status (R6, R7, R8).
  task automatic mode_run(bit pol, bit lvl);
    logic [PINS-1:0] v;
    logic [PINS-1:0] m;
    string tag;
    m = PINS'(1) << P;
    tag = lvl ? "R8" : "R7";
    wr(3, 0, '0);
    wr(6, pol ? 1 : 2, m);
    wr(5, lvl ? 1 : 2, m);
    pin_in = pol ? '0 : m;
    settle();
    wr(7, 2, '1);
    wr(3, 1, m);
    settle();
    rd(7, 0, v); check($sformatf("R6 idle mode=%0d%0d", pol, lvl), v, '0);
    pin_in = pol ? m : '0;
    settle();
    rd(7, 0, v); check($sformatf("R6 trigger mode=%0d%0d", pol, lvl), v, m);
    if (lvl) begin
      wr(7, 2, m);
      rd(7, 0, v); check("R8 level reasserts after clear", v, m);
    end
    pin_in = pol ? '0 : m;
    settle();
    rd(7, 0, v); check({tag, " sticky after release"}, v, m);
    wr(7, 2, m);
    settle();
    rd(7, 0, v); check("R10 cleared", v, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [PINS-1:0] v, m, exp_r [8];
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 pin_oe", pin_oe, '0);
    check("R1 pin_out", pin_out, '0);
    check("R1 irq", PINS'(irq), '0);
    for (int s = 0; s < 8; s++) begin
      rd(s, 0, v); check($sformatf("R1 slot %0d", s), v, '0);
    end

    // R2/R3: directed alias behaviour on output data and enable
    wr(0, 0, 32'hF0F0_1234); check("R3 pin_out load", pin_out, 32'hF0F0_1234);
    wr(0, 1, 32'h0000_000F); check("R2 set alias", pin_out, 32'hF0F0_123F);
    wr(0, 2, 32'hF000_0001); check("R2 clear alias", pin_out, 32'h00F0_123E);
    wr(0, 3, 32'hFFFF_FFFF); check("R2 offset 0xC ignored", pin_out, 32'h00F0_123E);
    wr(2, 1, 32'h8000_0001); check("R3 pin_oe set", pin_oe, 32'h8000_0001);
    // R4: read at every offset returns base value
    for (int a = 0; a < 4; a++) begin
      rd(0, a, v); check($sformatf("R4 alias %0d read", a), v, 32'h00F0_123E);
    end

    // R2/R3/R4 random register traffic against a model (pins held low)
    for (int s = 0; s < 8; s++) exp_r[s] = '0;
    exp_r[0] = 32'h00F0_123E; exp_r[2] = 32'h8000_0001;
    for (int i = 0; i < 200; i++) begin
      int s, a, ra;
      logic [PINS-1:0] d;
      s = 2 + int'($urandom_range(0, 4));
      if ($urandom_range(0, 3) == 0) s = 0;
      a = int'($urandom_range(0, 3));
      ra = int'($urandom_range(0, 3));
      d = $urandom;
      wr(s, a, d);
      exp_r[s] = model(exp_r[s], a, d);
      rd(s, ra, v); check($sformatf("R2 random slot %0d acc %0d", s, a), v, exp_r[s]);
    end
    check("R3 pin_out random", pin_out, exp_r[0]);
    check("R3 pin_oe random", pin_oe, exp_r[2]);
    wr(3, 0, '0); wr(4, 0, '0); wr(7, 2, '1);
    settle();
    rd(7, 0, v); check("R10 clear all", v, '0);

    // R5: input slot returns synchronised pins, writes ignored
    for (int i = 0; i < 4; i++) begin
      m = $urandom;
      pin_in = m;
      repeat (3) @(negedge clk);
      wr(1, 0, ~m);
      rd(1, i, v); check("R5 input read", v, m);
    end
    pin_in = '0;
    settle();

    // R6/R7/R8/R10 per mode on one pin
    mode_run(1'b0, 1'b0);
    mode_run(1'b0, 1'b1);
    mode_run(1'b1, 1'b0);
    mode_run(1'b1, 1'b1);

    // R7: rising mode ignores falling transition
    m = PINS'(1) << P;
    wr(5, 2, m); wr(6, 1, m); wr(3, 0, m);
    pin_in = m; settle(); wr(7, 2, '1);
    pin_in = '0; settle();
    rd(7, 0, v); check("R7 wrong edge ignored", v, '0);

    // R9: select bit off blocks status
    wr(3, 2, m);
    pin_in = m; settle();
    rd(7, 0, v); check("R9 unselected pin", v, '0);
    pin_in = '0; settle();

    // R11: enable mask gates irq
    wr(3, 1, m);
    pin_in = m; settle();
    check("R11 irq off while disabled", PINS'(irq), '0);
    wr(4, 0, ~m);
    repeat (3) @(negedge clk);
    check("R11 other enable only", PINS'(irq), '0);
    wr(4, 0, m);
    repeat (3) @(negedge clk);
    check("R11 irq asserted", PINS'(irq), 1);
    wr(7, 2, m);
    repeat (3) @(negedge clk);
    check("R11 irq cleared", PINS'(irq), '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule